// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the address and transfer-count datapath of one DMA channel. Software programs a 16-bit start address and a 16-bit transfer count through a byte-wide register-write port. Every write lands in both a base copy and a working (current) copy of the selected register. Each accepted byte-transfer strobe then steps the current address up or down and decrements the current count. The address wraps modulo 2^16, so the channel covers one 64K-byte window.

The count is programmed as the number of bytes minus one. The strobe that finds the count at zero is the terminal transfer, and the terminal-count output is raised during that strobe's cycle. With auto-initialization on, that strobe restores both current registers from their base copies and the channel keeps running. With it off, the channel halts and ignores strobes until software completes a new 16-bit write.

Top module: `dmac_chan_engine`

## Requirements
- R1: After reset, `cur_addr` and `cur_count` are 0, `halted` is 1, `tc` is 0, and the shared byte pointer selects the low byte.
- R2: Each write stores `wr_data` into one byte of the register chosen by `wr_cnt_sel` (0 = address, 1 = count). The byte is the low byte when the pointer is 0 and the high byte when it is 1. One pointer is shared by both registers and toggles on every write.
- R3: A write updates the base copy and the current copy of the selected byte together, so a later auto-initialization reload returns the programmed value.
- R4: A write to the high byte of either register clears `halted` at the next clock edge.
- R5: An accepted strobe adds 1 to `cur_address` when `mode_dec` is 0 and subtracts 1 when it is 1, wrapping modulo 2^16 (0xFFFF+1 = 0x0000, 0x0000−1 = 0xFFFF).
- R6: An accepted strobe decrements `cur_count` by one. A strobe is accepted when `xfer` is 1, `wr_en` is 0 and `halted` is 0.
- R7: `tc` is 1 during exactly the accepted strobe that finds `cur_count` at 0, so a programmed count of N−1 gives `tc` on the Nth strobe.
- R8: With `mode_auto` at 0, the terminal strobe still steps the address, leaves `cur_count` at 0xFFFF and sets `halted`.
- R9: With `mode_auto` at 1, the terminal strobe reloads `cur_addr` and `cur_count` from the base copies and leaves `halted` at 0.
- R10: When `wr_en` and `xfer` are both 1 in the same cycle, the write takes effect and the strobe is dropped: no step and no `tc`.
- R11: While `halted` is 1, strobes change neither current register and `tc` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register byte write strobe |
| wr_cnt_sel | input | 1 | Write target: 0 address, 1 count |
| wr_data | input | 8 | Write byte |
| mode_dec | input | 1 | 1 = address decrements per transfer |
| mode_auto | input | 1 | 1 = reload from base at terminal count |
| xfer | input | 1 | Byte-transfer strobe |
| cur_addr | output | 16 | Current transfer address |
| cur_count | output | 16 | Current remaining count (bytes − 1) |
| tc | output | 1 | Terminal count, during the terminal transfer |
| halted | output | 1 | Channel stopped, waiting for reprogramming |

## Verification
A CPU byte write and a transfer strobe can arrive in the same cycle. The block must then let the write win and drop the strobe entirely. The bench provokes this by raising `xfer` together with a low-byte address write while the count sits at zero, the case where the strobe would otherwise be terminal. It judges the result by `tc` staying low in that cycle, the count holding at zero, and the address showing only the newly written byte.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   typedef enum logic {
      SEL_ADDR = 1'b0,
      SEL_CNT  = 1'b1
   } dmac_sel_e;
endpackage

// File: rtl/dmac_prog_port.sv
module dmac_prog_port
   import dmac_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_cnt_sel,
   output logic [LANES-1:0] addr_lane_we,
   output logic [LANES-1:0] cnt_lane_we,
   output logic             wr_last
);
   localparam int PTR_W = (LANES > 1) ? $clog2(LANES) : 1;

   dmac_sel_e        sel;
   logic [LANES-1:0] lane_hit;

   assign sel = dmac_sel_e'(wr_cnt_sel);

   generate
      if (LANES > 1) begin : g_ptr
         logic [PTR_W-1:0] ptr_q;
         logic             at_top;

         assign at_top = (ptr_q == PTR_W'(LANES - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ptr_q <= '0;
            else if (wr_en)
               ptr_q <= at_top ? '0 : ptr_q + 1'b1;
         end

         for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign lane_hit[l] = wr_en && (ptr_q == PTR_W'(l));
         end
         assign wr_last = wr_en && at_top;
      end else begin : g_noptr
         assign lane_hit = wr_en;
         assign wr_last  = wr_en;
      end
   endgenerate

   assign addr_lane_we = (sel == SEL_ADDR) ? lane_hit : '0;
   assign cnt_lane_we  = (sel == SEL_CNT)  ? lane_hit : '0;
endmodule

// File: rtl/dmac_reg_pair.sv
module dmac_reg_pair #(
   parameter int BUS_W = 8,
   parameter int LANES = 2,
   localparam int W    = BUS_W * LANES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] lane_we,
   input  logic [BUS_W-1:0] wr_byte,
   input  logic             step_en,
   input  logic             step_down,
   input  logic             reload,
   output logic [W-1:0]     cur_q
);
   logic [W-1:0] base_q;
   logic [W-1:0] step_val;

   always_comb begin
      if (step_down)
         step_val = cur_q - {{(W-1){1'b0}}, 1'b1};
      else
         step_val = cur_q + {{(W-1){1'b0}}, 1'b1};
   end

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               base_q[l*BUS_W +: BUS_W] <= '0;
            else if (lane_we[l])
               base_q[l*BUS_W +: BUS_W] <= wr_byte;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cur_q[l*BUS_W +: BUS_W] <= '0;
            else if (lane_we[l])
               cur_q[l*BUS_W +: BUS_W] <= wr_byte;
            else if (reload)
               cur_q[l*BUS_W +: BUS_W] <= base_q[l*BUS_W +: BUS_W];
            else if (step_en)
               cur_q[l*BUS_W +: BUS_W] <= step_val[l*BUS_W +: BUS_W];
         end
      end
   endgenerate
endmodule

// File: rtl/dmac_chan_engine.sv
module dmac_chan_engine #(
   parameter int BUS_W  = 8,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_cnt_sel,
   input  logic [BUS_W-1:0]  wr_data,
   input  logic              mode_dec,
   input  logic              mode_auto,
   input  logic              xfer,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  cur_count,
   output logic              tc,
   output logic              halted
);
   localparam int LANES = ADDR_W / BUS_W;

   generate
      if (BUS_W < 1 || ADDR_W % BUS_W != 0) begin : g_bad_addr
         $error("ADDR_W must be a whole number of BUS_W bytes");
      end
      if (CNT_W != ADDR_W) begin : g_bad_cnt
         $error("CNT_W must equal ADDR_W: one byte pointer serves both");
      end
   endgenerate

   logic [LANES-1:0] addr_we;
   logic [LANES-1:0] cnt_we;
   logic             wr_last;
   logic             accept;
   logic             reload;
   logic             step;
   logic             halted_q;

   dmac_prog_port #(.LANES(LANES)) u_port (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_cnt_sel   (wr_cnt_sel),
      .addr_lane_we (addr_we),
      .cnt_lane_we  (cnt_we),
      .wr_last      (wr_last)
   );

   assign accept = xfer && !wr_en && !halted_q;
   assign tc     = accept && (cur_count == '0);
   assign reload = tc && mode_auto;
   assign step   = accept && !reload;

   dmac_reg_pair #(.BUS_W(BUS_W), .LANES(LANES)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .lane_we   (addr_we),
      .wr_byte   (wr_data),
      .step_en   (step),
      .step_down (mode_dec),
      .reload    (reload),
      .cur_q     (cur_addr)
   );

   dmac_reg_pair #(.BUS_W(BUS_W), .LANES(LANES)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .lane_we   (cnt_we),
      .wr_byte   (wr_data),
      .step_en   (step),
      .step_down (1'b1),
      .reload    (reload),
      .cur_q     (cur_count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         halted_q <= 1'b1;
      else if (wr_last)
         halted_q <= 1'b0;
      else if (tc && !mode_auto)
         halted_q <= 1'b1;
   end

   assign halted = halted_q;
endmodule

// File: rtl/dmac_chan_chk.sv
module dmac_chan_chk #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              mode_dec,
   input logic              mode_auto,
   input logic              xfer,
   input logic [ADDR_W-1:0] cur_addr,
   input logic [CNT_W-1:0]  cur_count,
   input logic              tc,
   input logic              halted
);
   logic take;
   assign take = xfer && !wr_en && !halted;

   AST_ADDR_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !(tc && mode_auto) && !mode_dec) |=> cur_addr == $past(cur_addr) + 1'b1); // R5
   AST_ADDR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !(tc && mode_auto) && mode_dec) |=> cur_addr == $past(cur_addr) - 1'b1); // R5
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !(tc && mode_auto)) |=> cur_count == $past(cur_count) - 1'b1); // R6
   AST_TC_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> (cur_count == '0) && take); // R7
   AST_HALT_ON_TC: assert property (@(posedge clk) disable iff (!rst_n)
      (tc && !mode_auto) |=> halted); // R8
   AST_AUTO_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      (tc && mode_auto) |=> !halted); // R9
   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !tc); // R10
   AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !wr_en) |=> $stable(cur_addr) && $stable(cur_count)); // R11
endmodule

bind dmac_chan_engine dmac_chan_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .mode_dec  (mode_dec),
   .mode_auto (mode_auto),
   .xfer      (xfer),
   .cur_addr  (cur_addr),
   .cur_count (cur_count),
   .tc        (tc),
   .halted    (halted)
);

// File: tb/tb_dmac_chan_engine.sv
module tb_dmac_chan_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_cnt_sel = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        mode_dec = 1'b0;
   logic        mode_auto = 1'b0;
   logic        xfer = 1'b0;
   logic [15:0] cur_addr;
   logic [15:0] cur_count;
   logic        tc;
   logic        halted;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   logic tc_seen;

   always #4 clk = ~clk;

   dmac_chan_engine dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cnt_sel(wr_cnt_sel),
      .wr_data(wr_data), .mode_dec(mode_dec), .mode_auto(mode_auto),
      .xfer(xfer), .cur_addr(cur_addr), .cur_count(cur_count),
      .tc(tc), .halted(halted)
   );

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // one cycle: drive at negedge, sample tc, finish at next negedge
   task automatic cycle(input logic we, input logic sel, input logic [7:0] d,
                        input logic xf);
      @(negedge clk);
      wr_en = we; wr_cnt_sel = sel; wr_data = d; xfer = xf;
      #1 tc_seen = tc;
      @(negedge clk);
      wr_en = 1'b0; xfer = 1'b0;
   endtask

   task automatic write16(input logic sel, input logic [15:0] v);
      cycle(1'b1, sel, v[7:0], 1'b0);
      cycle(1'b1, sel, v[15:8], 1'b0);
   endtask

   task automatic strobe(input string req, input logic exp_tc,
                         input logic [15:0] exp_a, input logic [15:0] exp_c);
      cycle(1'b0, 1'b0, 8'h00, 1'b1);
      check(req, "tc", {15'b0, tc_seen}, {15'b0, exp_tc});
      check(req, "addr", cur_addr, exp_a);
      check(req, "count", cur_count, exp_c);
   endtask

   task automatic t_reset;
      check("R1", "addr", cur_addr, 16'h0000);
      check("R1", "count", cur_count, 16'h0000);
      check("R1", "halted", {15'b0, halted}, 16'h0001);
      check("R1", "tc", {15'b0, tc}, 16'h0000);
      strobe("R11", 1'b0, 16'h0000, 16'h0000);
   endtask

   task automatic t_ptr_shared;
      cycle(1'b1, 1'b0, 8'hAA, 1'b0);  // address low byte
      cycle(1'b1, 1'b1, 8'h55, 1'b0);  // lands in count high byte
      check("R2", "addr low", {8'h00, cur_addr[7:0]}, 16'h00AA);
      check("R2", "count high", {8'h00, cur_count[15:8]}, 16'h0055);
      check("R4", "halted", {15'b0, halted}, 16'h0000);
   endtask

   task automatic t_inc_noauto;
      mode_dec = 1'b0; mode_auto = 1'b0;
      write16(1'b0, 16'h1234);
      write16(1'b1, 16'h0002);
      check("R2", "addr", cur_addr, 16'h1234);
      check("R3", "count", cur_count, 16'h0002);
      strobe("R6", 1'b0, 16'h1235, 16'h0001);
      strobe("R5", 1'b0, 16'h1236, 16'h0000);
      strobe("R7", 1'b1, 16'h1237, 16'hFFFF);
      check("R8", "halted", {15'b0, halted}, 16'h0001);
      strobe("R8", 1'b0, 16'h1237, 16'hFFFF);
   endtask

   task automatic t_dec_wrap;
      mode_dec = 1'b1; mode_auto = 1'b0;
      write16(1'b0, 16'h0001);
      write16(1'b1, 16'h0003);
      strobe("R5", 1'b0, 16'h0000, 16'h0002);
      strobe("R5", 1'b0, 16'hFFFF, 16'h0001);
      strobe("R5", 1'b0, 16'hFFFE, 16'h0000);
      strobe("R7", 1'b1, 16'hFFFD, 16'hFFFF);
      strobe("R11", 1'b0, 16'hFFFD, 16'hFFFF);
   endtask

   task automatic t_inc_wrap;
      mode_dec = 1'b0; mode_auto = 1'b0;
      write16(1'b0, 16'hFFFF);
      write16(1'b1, 16'h0005);
      strobe("R5", 1'b0, 16'h0000, 16'h0004);
   endtask

   task automatic t_auto;
      mode_dec = 1'b0; mode_auto = 1'b1;
      write16(1'b0, 16'h8000);
      write16(1'b1, 16'h0001);
      strobe("R6", 1'b0, 16'h8001, 16'h0000);
      strobe("R9", 1'b1, 16'h8000, 16'h0001);
      check("R9", "halted", {15'b0, halted}, 16'h0000);
      strobe("R3", 1'b0, 16'h8001, 16'h0000);
   endtask

   task automatic t_collide;
      // count is 0 here: a lone strobe would be terminal
      cycle(1'b1, 1'b0, 8'h34, 1'b1);
      check("R10", "tc", {15'b0, tc_seen}, 16'h0000);
      check("R10", "count", cur_count, 16'h0000);
      check("R10", "addr", cur_addr, 16'h8034);
      cycle(1'b1, 1'b0, 8'h12, 1'b0);
      check("R10", "addr full", cur_addr, 16'h1234);
   endtask

   initial begin
      #(8 * 20000);
      if (!finished) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ptr_shared();
      t_inc_noauto();
      t_dec_wrap();
      t_inc_wrap();
      t_auto();
      t_collide();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule